// File: doc/BRIEF.md
# Quad-Channel Double-Buffered Converter Register Bank

This block is the digital front end of a four-channel, 12-bit parallel-input digital-to-analog converter. Every channel owns two registers. The first level, the staging register, takes data from the parallel bus. The second level, the hold register, feeds the converter. A host selects a channel with a two-bit address and qualifies the access with an active-low select. It writes or reads with an R/W level. It moves staged data into the hold registers with an active-low load strobe. The load strobe can act on one channel during a write, or on all channels at once.

The host pins are asynchronous to the block, so they are brought into the system clock domain through a two-flop synchroniser before they are decoded. The transparent behaviour of the pin-level latches becomes a register update one clock after the decoded condition appears. The four hold-register codes leave the block on one flat bus for a behavioural converter model. The converter's output voltage is Vlow + (Vhigh − Vlow)·N/4096 for code N. An asynchronous active-low reset preloads every register with midscale or zero, depending on a parameter.

All pins carry plain levels. The host bus has no valid/ready handshake, because the pin protocol has no back-pressure: an access is taken as soon as it is decoded.

Top module: `quad_dac_regbank`

## Requirements
- R1: Channel address 0, 1, 2 and 3 selects channel A, B, C and D, and channel i's hold code appears on `dac_code[12*i+11:12*i]`. While `cs_n` is high, no staging register changes, whatever `addr`, `rw_n` and `data_in` carry.
- R2: A write is `cs_n`=0 and `rw_n`=0. It loads `data_in` into the addressed staging register, and the other staging registers keep their values. A pin pattern held across rising edge k takes effect at edge k+2, counting two synchroniser stages.
- R3: A write with `ld_n`=0 also loads `data_in` into the addressed hold register. The other hold registers keep their values.
- R4: A read is `cs_n`=0, `rw_n`=1 and `ld_n`=1. It raises `data_oe` and puts the addressed staging register on `data_out` (bit 11 is the MSB), one edge after the pattern is synchronised. All hold registers keep their values.
- R5: `cs_n`=1 with `ld_n`=0 copies all four staging registers into their hold registers on the same edge.
- R6: `cs_n`=1 with `ld_n`=1 leaves every register unchanged and keeps `data_oe` low.
- R7: `data_oe` is low during any write and while the block is unselected. `data_out` is zero whenever `data_oe` is low.
- R8: `rst_n`=0 forces every staging and hold register at once to 0x800 when `MIDSCALE`=1, or to 0x000 when `MIDSCALE`=0, regardless of `cs_n`. The values persist after release until a later access changes them.
- R9: `cs_n`=0, `rw_n`=1 and `ld_n`=0 copies all staging registers into the hold registers, and `data_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset to the reset code |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| rw_n | input | 1 | High reads, low writes, asynchronous |
| ld_n | input | 1 | Active-low load strobe, asynchronous |
| addr | input | 2 | Channel address |
| data_in | input | 12 | Write data from the bus |
| data_out | output | 12 | Readback data for the bus driver |
| data_oe | output | 1 | Bus driver enable, high during a decoded read |
| dac_code | output | 48 | Hold-register codes, channel i at bits 12*i+11:12*i |

## Verification
The corner that is hardest to reach from the ports is the set of pin combinations that fall between the named operations. One is a read with the load strobe low. Another is a write burst while chip select is high. A third is a reset that arrives mid-sequence, with staged data that differs from the hold data. The stimulus builds each case on purpose: it writes distinct codes into all four staging registers first, so that any wrongly taken copy or write shows up on the hold bus. A long stretch of random pin patterns then follows. A behavioural model, delayed through a two-entry queue, predicts every register and the bus on every clock, for a midscale instance and a zero-scale instance side by side.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  // Reset code of a DW-bit channel: MSB only for midscale, all zero otherwise.
  function automatic logic [31:0] reset_code(input bit mid, input int unsigned dw);
    logic [31:0] c;
    c = '0;
    if (mid) c[dw-1] = 1'b1;
    return c;
  endfunction
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int          W      = 8,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] IDLE  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pipe[s] <= IDLE;
      else if (s == 0) pipe[s] <= d;
      else             pipe[s] <= pipe[(s == 0) ? 0 : s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/qdac_decode.sv
module qdac_decode #(
  parameter int NCH = 4,
  localparam int AW = $clog2(NCH)
) (
  input  logic          cs_n,
  input  logic          rw_n,
  input  logic          ld_n,
  input  logic [AW-1:0] addr,
  output logic [NCH-1:0] wr_sel,
  output logic          wr_thru,
  output logic          load_all,
  output logic          rd_en
);
  logic sel, wr;

  assign sel      = !cs_n;
  assign wr       = sel && !rw_n;
  assign wr_thru  = wr && !ld_n;
  assign load_all = !ld_n && !wr;
  assign rd_en    = sel && rw_n && ld_n;

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign wr_sel[i] = wr && (addr == AW'(i));
  end
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank #(
  parameter int          NCH      = 4,
  parameter int          DW       = 12,
  parameter logic [DW-1:0] RST_CODE = '0,
  localparam int         AW       = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    wr_sel,
  input  logic              wr_thru,
  input  logic              load_all,
  input  logic [DW-1:0]     wdata,
  input  logic [AW-1:0]     rd_idx,
  output logic [DW-1:0]     rd_data,
  output logic [NCH*DW-1:0] hold_flat
);
  logic [DW-1:0] stage_q [NCH];
  logic [DW-1:0] hold_q  [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         stage_q[i] <= RST_CODE;
      else if (wr_sel[i]) stage_q[i] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     hold_q[i] <= RST_CODE;
      else if (wr_sel[i] && wr_thru)  hold_q[i] <= wdata;
      else if (load_all)              hold_q[i] <= stage_q[i];
    end

    assign hold_flat[i*DW +: DW] = hold_q[i];

    p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[i] |=> stage_q[i] == $past(wdata));
    p_thru_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel[i] && wr_thru) |=> hold_q[i] == $past(wdata));
    p_gload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load_all |=> hold_q[i] == $past(stage_q[i]));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_all && !(wr_sel[i] && wr_thru)) |=> $stable(hold_q[i]));
  end

  assign rd_data = stage_q[rd_idx];
endmodule

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank #(
  parameter int NCH         = 4,
  parameter int DW          = 12,
  parameter bit MIDSCALE    = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      rw_n,
  input  logic                      ld_n,
  input  logic [$clog2(NCH)-1:0]    addr,
  input  logic [DW-1:0]             data_in,
  output logic [DW-1:0]             data_out,
  output logic                      data_oe,
  output logic [NCH*DW-1:0]         dac_code
);
  localparam int AW = $clog2(NCH);
  localparam int CW = 3 + AW + DW;
  localparam logic [DW-1:0] RST_CODE = DW'(qdac_pkg::reset_code(MIDSCALE, DW));
  localparam logic [CW-1:0] IDLE_PINS = {3'b111, {AW{1'b0}}, {DW{1'b0}}};

  logic [CW-1:0]  pins_s;
  logic           cs_n_s, rw_n_s, ld_n_s;
  logic [AW-1:0]  addr_s;
  logic [DW-1:0]  data_s;
  logic [NCH-1:0] wr_sel;
  logic           wr_thru, load_all, rd_en;
  logic [DW-1:0]  rd_data;

  qdac_sync #(.W(CW), .STAGES(SYNC_STAGES), .IDLE(IDLE_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, rw_n, ld_n, addr, data_in}),
    .q(pins_s)
  );

  assign {cs_n_s, rw_n_s, ld_n_s, addr_s, data_s} = pins_s;

  qdac_decode #(.NCH(NCH)) u_dec (
    .cs_n(cs_n_s), .rw_n(rw_n_s), .ld_n(ld_n_s), .addr(addr_s),
    .wr_sel(wr_sel), .wr_thru(wr_thru), .load_all(load_all), .rd_en(rd_en)
  );

  qdac_bank #(.NCH(NCH), .DW(DW), .RST_CODE(RST_CODE)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_sel(wr_sel), .wr_thru(wr_thru), .load_all(load_all),
    .wdata(data_s), .rd_idx(addr_s), .rd_data(rd_data),
    .hold_flat(dac_code)
  );

  assign data_oe  = rd_en;
  assign data_out = rd_en ? rd_data : '0;

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s || !rw_n_s) |-> (!data_oe && data_out == '0));
  p_unsel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> wr_sel == '0);
  p_rdload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_s && rw_n_s && !ld_n_s) |-> (load_all && !data_oe));
endmodule

// File: tb/quad_dac_regbank_tb_top.sv
module quad_dac_regbank_tb_top;
  localparam int NCH = 4;
  localparam int DW  = 12;

  typedef struct packed {
    logic       cs_n, rw_n, ld_n;
    logic [1:0] addr;
    logic [11:0] data;
  } pins_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rw_n = 1'b1, ld_n = 1'b1;
  logic [1:0]  addr = '0;
  logic [11:0] din = '0;
  logic [11:0] dout_m, dout_z;
  logic        oe_m, oe_z;
  logic [47:0] code_m, code_z;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string phase = "R8";

  always #2 clk = ~clk;

  quad_dac_regbank #(.MIDSCALE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw_n(rw_n), .ld_n(ld_n),
    .addr(addr), .data_in(din), .data_out(dout_m), .data_oe(oe_m), .dac_code(code_m));

  quad_dac_regbank #(.MIDSCALE(1'b0)) dut_z_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw_n(rw_n), .ld_n(ld_n),
    .addr(addr), .data_in(din), .data_out(dout_z), .data_oe(oe_z), .dac_code(code_z));

  // Behavioural reference: variant 0 is midscale, variant 1 is zero scale.
  int m_stage [2][NCH];
  int m_hold  [2][NCH];
  pins_t hist[$];
  localparam pins_t IDLE = '{cs_n:1'b1, rw_n:1'b1, ld_n:1'b1, addr:2'd0, data:12'd0};

  function automatic pins_t synced();
    return (hist.size() == 2) ? hist[0] : IDLE;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete();
      for (int v = 0; v < 2; v++)
        for (int c = 0; c < NCH; c++) begin
          m_stage[v][c] = (v == 0) ? 'h800 : 0;
          m_hold[v][c]  = (v == 0) ? 'h800 : 0;
        end
    end else begin
      pins_t e;
      e = synced();
      for (int v = 0; v < 2; v++) begin
        if (!e.cs_n && !e.rw_n) begin
          m_stage[v][e.addr] = e.data;
          if (!e.ld_n) m_hold[v][e.addr] = e.data;
        end else if (!e.ld_n) begin
          for (int c = 0; c < NCH; c++) m_hold[v][c] = m_stage[v][c];
        end
      end
      hist.push_back('{cs_n:cs_n, rw_n:rw_n, ld_n:ld_n, addr:addr, data:din});
      while (hist.size() > 2) void'(hist.pop_front());
    end
  end

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      pins_t e;
      bit exp_oe;
      e = synced();
      exp_oe = !e.cs_n && e.rw_n && e.ld_n;
      for (int v = 0; v < 2; v++) begin
        logic [47:0] cb;
        logic oe;
        logic [11:0] dq;
        cb = v ? code_z : code_m;
        oe = v ? oe_z : oe_m;
        dq = v ? dout_z : dout_m;
        check(exp_oe ? "R4" : "R7", int'(oe), int'(exp_oe), "data_oe");
        check(exp_oe ? phase : "R7", int'(dq), exp_oe ? m_stage[v][e.addr] : 0, "data_out");
        for (int c = 0; c < NCH; c++)
          check(phase, int'(cb[c*12 +: 12]), m_hold[v][c], $sformatf("hold ch%0d v%0d", c, v));
      end
    end
  end

  task automatic drive(input logic c, input logic r, input logic l,
                       input logic [1:0] a, input logic [11:0] d, input int n);
    @(posedge clk); #1;
    cs_n = c; rw_n = r; ld_n = l; addr = a; din = d;
    repeat (n - 1) @(posedge clk);
  endtask

  task automatic idle(input int n);
    drive(1'b1, 1'b1, 1'b1, addr, din, n);
  endtask

  logic [11:0] wv [NCH];

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      check("R8", int'(code_m[c*12 +: 12]), 'h800, "midscale reset");
      check("R8", int'(code_z[c*12 +: 12]), 0, "zero reset");
    end

    phase = "R2";
    for (int c = 0; c < NCH; c++) begin
      wv[c] = 12'h111 * 12'(c + 1) + 12'h0a5;
      drive(1'b0, 1'b0, 1'b1, 2'(c), wv[c], 1);
      idle(3);
    end
    phase = "R4";
    for (int c = 0; c < NCH; c++) begin
      drive(1'b0, 1'b1, 1'b1, 2'(c), 12'h000, 4);
      idle(2);
    end
    phase = "R5";
    drive(1'b1, 1'b1, 1'b0, 2'd0, 12'h000, 1);
    idle(4);
    @(negedge clk);
    for (int c = 0; c < NCH; c++)
      check("R1", int'(code_m[c*12 +: 12]), int'(wv[c]), "channel slice after global load");

    phase = "R3";
    drive(1'b0, 1'b0, 1'b0, 2'd2, 12'hfff, 1);
    idle(4);
    drive(1'b0, 1'b0, 1'b1, 2'd1, 12'h123, 1);
    idle(3);
    phase = "R9";
    drive(1'b0, 1'b1, 1'b0, 2'd3, 12'h000, 2);
    idle(4);

    phase = "R1";
    drive(1'b1, 1'b0, 1'b1, 2'd0, 12'h3c3, 2);
    drive(1'b1, 1'b0, 1'b1, 2'd3, 12'h0f0, 2);
    idle(3);
    for (int c = 0; c < NCH; c++) drive(1'b0, 1'b1, 1'b1, 2'(c), 12'h000, 3);
    phase = "R6";
    for (int k = 0; k < 6; k++) drive(1'b1, 1'b1, 1'b1, 2'($urandom_range(3)), 12'($urandom), 1);
    idle(3);

    phase = "R8";
    drive(1'b0, 1'b0, 1'b1, 2'd1, 12'h777, 1);
    #0 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(3);
    for (int c = 0; c < NCH; c++) drive(1'b0, 1'b1, 1'b1, 2'(c), 12'h000, 3);

    phase = "R1";
    for (int k = 0; k < 400; k++)
      drive(1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(3) != 0),
            2'($urandom_range(3)), 12'($urandom), 1 + $urandom_range(2));
    idle(4);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule